// File: doc/BRIEF.md
# Pipelined binary32 to signed 32-bit integer converter

This block turns an IEEE-754 single-precision value into a two's-complement 32-bit integer. The rounding mode is chosen per operand. Each accepted operand produces exactly one result, a fixed number of cycles later. Operands may arrive on every cycle or with gaps, and results leave in the order their operands came in. The block suits an execution pipe that needs a float-to-integer step with a fixed, known delay.

The first stage sorts every operand into one of four classes:
- `CLS_INVALID`: out of range, NaN or infinity.
- `CLS_ZERO`: exact zero, or a small magnitude that rounds to zero.
- `CLS_UNIT`: a small magnitude that rounds to plus or minus one.
- `CLS_RANGE`: a magnitude that needs real work.

The same stage computes the right-shift distance with its own subtractor. In `CLS_RANGE`, the later stages do the following:
- align the significand, gathering the shifted-out bits into a sticky bit;
- round, and recheck the magnitude;
- apply the sign.

Early classes skip that work but still travel down the pipe. The latency therefore stays the same in every case.

The class is the only state that changes on the way. The one transition is `CLS_RANGE` to `CLS_INVALID` in the rounding stage, taken when the rounded magnitude reaches 2^31. All other classes pass through unchanged.

Top module: `fcvt_f32_s32`

## Requirements
- R1: An operand whose biased exponent (bits 30:23) is 158 or more, which includes NaN and infinity, gives `out_invalid` = 1 and `out_result` = 0x80000000.
- R2: Positive and negative zero (bits 30:0 all clear) give 0 with `out_invalid` = 0 under every rounding mode.
- R3: A nonzero operand with biased exponent below 127 gives 0 under any of these conditions:
  - mode 01 (toward zero);
  - mode 10 (toward minus infinity) with sign bit 31 clear;
  - mode 11 (toward plus infinity) with sign bit 31 set.
- R4: A nonzero operand with biased exponent below 127 gives -1 (0xFFFFFFFF) under mode 10 when negative. It gives +1 under mode 11 when positive.
- R5: Under mode 00 (nearest, ties to even), the rules for a biased exponent below 127 are:
  - An exponent below 126 gives 0.
  - An exponent of 126 with a zero fraction field (exactly one half) gives 0.
  - An exponent of 126 with a nonzero fraction gives +1 or -1, following the sign.
- R6: Operands with biased exponent 127 to 157 that hold whole numbers convert exactly under every mode.
- R7: Operands with biased exponent 127 to 149 that are not whole numbers round as follows, with the sticky bit taking part in every decision:
  - mode 00: to nearest, ties to the even integer;
  - mode 01: toward zero;
  - mode 10: toward minus infinity;
  - mode 11: toward plus infinity.
- R8: 0x80000000 never appears without `out_invalid`. The largest in-range magnitudes (2^31-128, either sign) convert without the flag.
- R9: A negative in-range operand gives the two's-complement negation of its rounded magnitude.
- R10: Each `in_valid` pulse produces one `out_valid` pulse on the fourth rising edge, counting the edge that samples the operand. This holds for back-to-back operands and for operands with gaps.
- R11: While `rst_n` is low, `out_valid`, `out_result` and `out_invalid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_value | input | 32 | binary32 operand |
| in_rmode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 32 | Signed integer result |
| out_invalid | output | 1 | Operand could not be represented; result saturated to 0x80000000 |

## Verification
The hardest cases to reach are the rounding decisions that hinge on one bit: an exact tie against a tie plus a single set bit far below the guard position, which only the sticky OR can reveal. Random fractions almost never land on these. The stimulus therefore builds those operands field by field: exponent 128 with fraction 0x200000 against 0x200001, and exponent 127 with only fraction bit 0 set. Each is sent under all four modes and both signs. The boundary exponents 126, 127, 157 and 158 are sent the same way. A random sweep over exponents 100 to 162 then runs back-to-back with gaps, and a scoreboard compares every result against an independent integer model, in arrival order and at the stated latency.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int INT_W   = 32;
    localparam int MAG_W   = INT_W - 1;
    localparam int GRS_W   = 3;
    localparam int ALIGN_W = MAG_W + GRS_W;
    localparam int SH_W    = $clog2(MAG_W);
    localparam int BIAS    = 127;

    localparam logic [EXP_W-1:0] EXP_HALF  = EXP_W'(BIAS - 1);
    localparam logic [EXP_W-1:0] EXP_ONE   = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] EXP_LIMIT = EXP_W'(BIAS + INT_W - 1);
    localparam logic [EXP_W-1:0] EXP_TOP   = EXP_W'(BIAS + INT_W - 2);
    localparam logic [INT_W-1:0] INT_MIN   = {1'b1, {(INT_W-1){1'b0}}};

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_DOWN    = 2'b10,
        RM_UP      = 2'b11
    } rmode_t;

    typedef enum logic [1:0] {
        CLS_RANGE,
        CLS_INVALID,
        CLS_ZERO,
        CLS_UNIT
    } cls_t;
endpackage

// File: rtl/fcvt_classify.sv
module fcvt_classify
    import fcvt_pkg::*;
(
    input  logic [INT_W-1:0] value,
    input  rmode_t           rmode,
    output cls_t             cls,
    output logic             sign,
    output logic [SH_W-1:0]  shamt,
    output logic [SIG_W-1:0] sig
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              mag_zero;

    assign sign     = value[INT_W-1];
    assign exp_f    = value[INT_W-2 -: EXP_W];
    assign frac_f   = value[FRAC_W-1:0];
    assign mag_zero = (exp_f == '0) && (frac_f == '0);
    assign sig      = {1'b1, frac_f};
    // own subtractor: distance from the top in-range exponent
    assign shamt    = SH_W'(EXP_TOP - exp_f);

    always_comb begin
        cls = CLS_RANGE;
        if (exp_f >= EXP_LIMIT) begin
            cls = CLS_INVALID;
        end else if (mag_zero) begin
            cls = CLS_ZERO;
        end else if (exp_f < EXP_ONE) begin
            unique case (rmode)
                RM_NEAREST: cls = (exp_f == EXP_HALF && frac_f != '0) ? CLS_UNIT : CLS_ZERO;
                RM_ZERO:    cls = CLS_ZERO;
                RM_DOWN:    cls = sign ? CLS_UNIT : CLS_ZERO;
                RM_UP:      cls = sign ? CLS_ZERO : CLS_UNIT;
            endcase
        end
    end
endmodule

// File: rtl/fcvt_align.sv
module fcvt_align
    import fcvt_pkg::*;
(
    input  logic [SIG_W-1:0] sig,
    input  logic [SH_W-1:0]  shamt,
    output logic [MAG_W-1:0] mag,
    output logic [GRS_W-1:0] grs
);
    logic [ALIGN_W-1:0] wide;
    logic [ALIGN_W-1:0] shifted;
    logic [ALIGN_W-1:0] lost_mask;
    logic               lost;

    assign wide      = {sig, {(ALIGN_W-SIG_W){1'b0}}};
    assign shifted   = wide >> shamt;
    assign lost_mask = ~({ALIGN_W{1'b1}} << shamt);
    assign lost      = |(wide & lost_mask);
    assign mag       = shifted[ALIGN_W-1:GRS_W];
    assign grs       = {shifted[2], shifted[1], shifted[0] | lost};
endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
    import fcvt_pkg::*;
(
    input  logic [MAG_W-1:0] mag,
    input  logic [GRS_W-1:0] grs,
    input  logic             sign,
    input  rmode_t           rmode,
    output logic [MAG_W:0]   rounded
);
    logic inexact;
    logic inc;

    assign inexact = |grs;

    always_comb begin
        unique case (rmode)
            RM_NEAREST: inc = grs[2] & (grs[1] | grs[0] | mag[0]);
            RM_ZERO:    inc = 1'b0;
            RM_DOWN:    inc = sign & inexact;
            RM_UP:      inc = ~sign & inexact;
        endcase
    end

    assign rounded = {1'b0, mag} + (MAG_W+1)'(inc);

    // R7: an exact magnitude is never bumped
    always_comb begin
        if (inc) begin
            assert_exact_kept_R7: assert (grs != '0);
        end
    end
endmodule

// File: rtl/fcvt_f32_s32.sv
module fcvt_f32_s32
    import fcvt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [INT_W-1:0] in_value,
    input  logic [1:0]       in_rmode,
    output logic             out_valid,
    output logic [INT_W-1:0] out_result,
    output logic             out_invalid
);
    // stage 1 outputs (combinational) and registers
    cls_t             c1_cls;
    logic             c1_sign;
    logic [SH_W-1:0]  c1_shamt;
    logic [SIG_W-1:0] c1_sig;

    logic             s1_valid, s1_sign;
    cls_t             s1_cls;
    rmode_t           s1_rmode;
    logic [SH_W-1:0]  s1_shamt;
    logic [SIG_W-1:0] s1_sig;

    logic [MAG_W-1:0] c2_mag;
    logic [GRS_W-1:0] c2_grs;

    logic             s2_valid, s2_sign;
    cls_t             s2_cls;
    rmode_t           s2_rmode;
    logic [MAG_W-1:0] s2_mag;
    logic [GRS_W-1:0] s2_grs;

    logic [MAG_W:0]   c3_rounded;
    cls_t             c3_cls;

    logic             s3_valid, s3_sign;
    cls_t             s3_cls;
    logic [MAG_W-1:0] s3_mag;

    logic [INT_W-1:0] c4_result;
    logic             c4_invalid;

    fcvt_classify u_classify (
        .value (in_value),
        .rmode (rmode_t'(in_rmode)),
        .cls   (c1_cls),
        .sign  (c1_sign),
        .shamt (c1_shamt),
        .sig   (c1_sig)
    );

    fcvt_align u_align (
        .sig   (s1_sig),
        .shamt (s1_shamt),
        .mag   (c2_mag),
        .grs   (c2_grs)
    );

    fcvt_round u_round (
        .mag     (s2_mag),
        .grs     (s2_grs),
        .sign    (s2_sign),
        .rmode   (s2_rmode),
        .rounded (c3_rounded)
    );

    // class transition: CLS_RANGE -> CLS_INVALID on a carry into bit 31
    assign c3_cls = (s2_cls == CLS_RANGE && c3_rounded[MAG_W]) ? CLS_INVALID : s2_cls;

    always_comb begin
        unique case (s3_cls)
            CLS_RANGE: begin
                c4_result  = s3_sign ? -{1'b0, s3_mag} : {1'b0, s3_mag};
                c4_invalid = 1'b0;
            end
            CLS_INVALID: begin
                c4_result  = INT_MIN;
                c4_invalid = 1'b1;
            end
            CLS_ZERO: begin
                c4_result  = '0;
                c4_invalid = 1'b0;
            end
            CLS_UNIT: begin
                c4_result  = s3_sign ? {INT_W{1'b1}} : INT_W'(1);
                c4_invalid = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0; s1_sign <= 1'b0; s1_cls <= CLS_ZERO;
            s1_rmode <= RM_NEAREST; s1_shamt <= '0; s1_sig <= '0;
            s2_valid <= 1'b0; s2_sign <= 1'b0; s2_cls <= CLS_ZERO;
            s2_rmode <= RM_NEAREST; s2_mag <= '0; s2_grs <= '0;
            s3_valid <= 1'b0; s3_sign <= 1'b0; s3_cls <= CLS_ZERO; s3_mag <= '0;
            out_valid <= 1'b0; out_result <= '0; out_invalid <= 1'b0;
        end else begin
            s1_valid <= in_valid; s1_sign <= c1_sign; s1_cls <= c1_cls;
            s1_rmode <= rmode_t'(in_rmode); s1_shamt <= c1_shamt; s1_sig <= c1_sig;
            s2_valid <= s1_valid; s2_sign <= s1_sign; s2_cls <= s1_cls;
            s2_rmode <= s1_rmode; s2_mag <= c2_mag; s2_grs <= c2_grs;
            s3_valid <= s2_valid; s3_sign <= s2_sign; s3_cls <= c3_cls;
            s3_mag <= c3_rounded[MAG_W-1:0];
            out_valid <= s3_valid; out_result <= c4_result; out_invalid <= c4_invalid;
        end
    end

    // cycles since reset, saturating, so $past never reaches into reset
    logic [2:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age <= '0;
        else if (age != 3'd4)    age <= age + 3'd1;
    end

    assert_fixed_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    assert_invalid_saturates_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (out_result == INT_MIN));

    assert_no_unflagged_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_invalid) |-> (out_result != INT_MIN));

    assert_small_gives_unit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 3'd4 && out_valid && $past(in_value[INT_W-2 -: EXP_W], 4) < EXP_ONE)
        |-> (!out_invalid && (out_result == '0 || out_result == INT_W'(1)
                              || out_result == {INT_W{1'b1}})));

    assert_sign_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 3'd4 && out_valid && !out_invalid && out_result != '0)
        |-> (out_result[INT_W-1] == $past(in_value[INT_W-1], 4)));
endmodule

// File: tb/fcvt_f32_s32_tb_top.sv
module fcvt_f32_s32_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_value;
    logic [1:0]  in_rmode;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_invalid;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        inv;
        int          stamp;
        string       tag;
    } exp_t;
    exp_t sb[$];

    fcvt_f32_s32 dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_value    (in_value),
        .in_rmode    (in_rmode),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_invalid (out_invalid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mkf(input logic s, input int e, input int f);
        return {s, 8'(e), 23'(f)};
    endfunction

    // independent model built from the requirements
    function automatic void ref_conv(input logic [31:0] x, input logic [1:0] m,
                                     output logic [31:0] r, output logic inv);
        logic   s;
        int     e;
        longint sig, q, rem, half, mag, inc;
        logic   unit;
        s   = x[31];
        e   = int'(x[30:23]);
        sig = longint'({1'b1, x[22:0]});
        inv = 1'b0;
        r   = 32'd0;
        if (e >= 158) begin
            inv = 1'b1; r = 32'h8000_0000;
        end else if (x[30:0] == 31'd0) begin
            r = 32'd0;
        end else if (e < 127) begin
            case (m)
                2'b00:   unit = (e == 126) && (x[22:0] != 23'd0);
                2'b01:   unit = 1'b0;
                2'b10:   unit = s;
                default: unit = !s;
            endcase
            r = unit ? (s ? 32'hFFFF_FFFF : 32'd1) : 32'd0;
        end else begin
            if (e >= 150) begin
                mag = sig <<< (e - 150);
            end else begin
                q    = sig >>> (150 - e);
                rem  = sig - (q <<< (150 - e));
                half = longint'(1) <<< (149 - e);
                case (m)
                    2'b00:   inc = ((rem > half) || (rem == half && q[0])) ? 1 : 0;
                    2'b01:   inc = 0;
                    2'b10:   inc = (s && rem != 0) ? 1 : 0;
                    default: inc = (!s && rem != 0) ? 1 : 0;
                endcase
                mag = q + inc;
            end
            if (mag >= 64'sh8000_0000) begin
                inv = 1'b1; r = 32'h8000_0000;
            end else begin
                r = s ? 32'(-mag) : 32'(mag);
            end
        end
    endfunction

    task automatic send(input logic [31:0] v, input logic [1:0] m, input string tag);
        exp_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_value = v;
        in_rmode = m;
        ref_conv(v, m, it.res, it.inv);
        it.stamp = cyc;
        it.tag   = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic all_modes(input logic [31:0] v, input string tag);
        for (int m = 0; m < 4; m++) send(v, 2'(m), tag);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t it;
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R10: out_valid with nothing pending, result %h", out_result);
            end else begin
                it = sb.pop_front();
                if (out_result !== it.res || out_invalid !== it.inv) begin
                    fails++;
                    $display("FAIL %s: got result %h invalid %b, expected %h invalid %b",
                             it.tag, out_result, out_invalid, it.res, it.inv);
                end
                if (cyc - it.stamp != 4) begin
                    fails++;
                    $display("FAIL R10: latency got %0d expected 4", cyc - it.stamp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_value = '0; in_rmode = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_result !== 32'd0 || out_invalid !== 1'b0) begin
            fails++;
            $display("FAIL R11: got %b %h %b expected 0 0 0", out_valid, out_result, out_invalid);
        end
        rst_n = 1'b1;
        idle(2);

        // R1: out of range, infinity, NaN
        send(mkf(0, 255, 0), 2'b00, "R1");
        send(mkf(1, 255, 0), 2'b01, "R1");
        send(mkf(0, 255, 1), 2'b10, "R1");
        send(mkf(0, 158, 0), 2'b11, "R1");
        send(mkf(1, 158, 0), 2'b00, "R1");
        idle(1);
        // R2: signed zeros
        all_modes(mkf(0, 0, 0), "R2");
        all_modes(mkf(1, 0, 0), "R2");
        // R3, R4: small magnitudes including a subnormal
        all_modes(mkf(0, 126, 32'h400000), "R3");
        all_modes(mkf(1, 126, 32'h400000), "R4");
        all_modes(mkf(0, 0, 1), "R3");
        all_modes(mkf(1, 100, 5), "R4");
        idle(3);
        // R5: nearest-even boundaries
        send(mkf(0, 125, 32'h7FFFFF), 2'b00, "R5");
        send(mkf(0, 126, 0), 2'b00, "R5");
        send(mkf(1, 126, 0), 2'b00, "R5");
        send(mkf(0, 126, 1), 2'b00, "R5");
        send(mkf(1, 126, 1), 2'b00, "R5");
        // R6: whole numbers
        all_modes(mkf(0, 127, 0), "R6");
        all_modes(mkf(0, 128, 32'h400000), "R6");
        all_modes(mkf(1, 133, 32'h480000), "R6");
        all_modes(mkf(0, 150, 32'h012345), "R6");
        idle(2);
        // R7: ties, above-tie via sticky, lowest fraction bit
        all_modes(mkf(0, 128, 32'h200000), "R7");
        all_modes(mkf(1, 128, 32'h200000), "R7");
        all_modes(mkf(0, 128, 32'h600000), "R7");
        all_modes(mkf(0, 128, 32'h200001), "R7");
        all_modes(mkf(1, 128, 32'h200001), "R7");
        all_modes(mkf(0, 127, 1), "R7");
        all_modes(mkf(1, 127, 1), "R7");
        all_modes(mkf(0, 149, 32'h7FFFFF), "R7");
        // R8, R9: extremes of the range
        all_modes(mkf(0, 157, 32'h7FFFFF), "R8");
        all_modes(mkf(1, 157, 32'h7FFFFF), "R9");
        all_modes(mkf(1, 140, 32'h5A5A5A), "R9");
        idle(4);

        // random sweep with gaps (R7, R10)
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] v;
            v = mkf(1'($urandom), 100 + int'($urandom_range(0, 62)), int'($urandom));
            send(v, 2'($urandom), "R7");
            if ($urandom_range(0, 7) == 0) idle(1 + int'($urandom_range(0, 3)));
        end
        idle(8);

        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R10: got %0d results missing, expected 0", sb.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule